// File: doc/BRIEF.md
# Parallel Permutation-Polynomial Address Generator

This block turns one base index into eight interleaved addresses at once, for a quadratic permutation polynomial interleaver over block lengths of up to 6144. A consumer such as a parallel decoder asks for addresses by index. Each cycle it presents a base index `b`, and the block returns π(x) = (f1·x + f2·x²) mod N for every x from b to b+7. No lane depends on the address that another lane computes. The coefficients f1 and f2 and the length N are held in configuration registers that are written through a load strobe.

Every lane evaluates the polynomial in a factored form: ((f1 + (f2·x mod N)) mod N)·x mod N. Every product in this form is below N·N, so all intermediate values fit in 26 bits. Each modulo step is a chain of conditional subtractions that works for any N from 1 to 6144. The datapath has five register stages. It accepts one request per cycle and applies backpressure from the output through a valid/ready pair.

Top module: `qpp_addr_gen`

## Requirements
- R1: For 1 ≤ N ≤ 6144 with f1 < N and f2 < N, lane i (bits [13i+12:13i] of `out_addr`) carries (f1·x + f2·x²) mod N for x = base + i.
- R2: Bit i of `out_lane_ok` is 1 exactly when base + i < N. A lane whose bit is 0 carries address 0.
- R3: With `out_ready` held high, a request accepted at clock edge k makes `out_valid` high after edge k+4 and not earlier. One request can be accepted on every cycle.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_lane_ok` hold their values and `req_ready` is low.
- R5: Results leave the block in the order in which their requests were accepted.
- R6: When no request is in flight, a `cfg_load` pulse captures `cfg_n`, `cfg_f1` and `cfg_f2`, and every later request uses these values. `req_ready` is low in any cycle where `cfg_load` is high.
- R7: A `cfg_load` pulse while any request is in flight or waiting at the output has no effect. Both the in-flight results and later requests use the previous configuration.
- R8: After reset, `out_valid` is low and `req_ready` is high.
- R9: For the legal sets (N, f1, f2) = (40,3,10), (512,31,64), (1024,31,64) and (6144,263,480), a sweep of bases 0, 8, … below N produces every value 0 … N-1 exactly once across the valid lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Strobe that captures the configuration when the block is idle |
| cfg_n | input | 13 | Block length N (1 … 6144) |
| cfg_f1 | input | 13 | Linear coefficient, below N |
| cfg_f2 | input | 13 | Quadratic coefficient, below N |
| req_valid | input | 1 | Base index request is valid |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_base | input | 13 | First index of the group of eight |
| out_valid | output | 1 | Address group is valid |
| out_ready | input | 1 | Consumer takes the address group |
| out_addr | output | 104 | Eight packed 13-bit addresses, lane 0 in the low bits |
| out_lane_ok | output | 8 | Lane i holds a real address |

## Verification
The hardest case to reach is a configuration strobe that arrives while a request is still inside the pipeline. The bench sets this up directly: it issues a single request and pulses `cfg_load` with different coefficients on the very next cycle. It then checks both that result and a later request against the old coefficients. Partially valid groups appear only when N is not a multiple of eight or the base lies close to N. Directed bases of N-3, together with random lengths and bases that reach past N, cover these groups. Randomly timed `out_ready` drops keep the pipeline full and stalled while the permutation sweeps run.

// File: rtl/qpp_pkg.sv
package qpp_pkg;
  parameter int unsigned QPP_NMAX = 6144;
  localparam int IDX_W = $clog2(QPP_NMAX);

  typedef logic [IDX_W-1:0] idx_t;

  typedef struct packed {
    idx_t n;
    idx_t f1;
    idx_t f2;
  } qpp_cfg_t;
endpackage

// File: rtl/qpp_modred.sv
// Reduces val_i modulo mod_i by conditional subtraction of mod_i<<s,
// s = SH-1 down to 0. Precondition: val_i < mod_i * 2**SH.
module qpp_modred #(
  parameter int W  = 26,
  parameter int SH = 13,
  parameter int MW = 13
) (
  input  logic [W-1:0]  val_i,
  input  logic [MW-1:0] mod_i,
  output logic [MW-1:0] rem_o
);
  function automatic logic [MW-1:0] reduce(input logic [W-1:0] v_in,
                                           input logic [MW-1:0] m);
    logic [W-1:0] v;
    logic [W-1:0] sub;
    v = v_in;
    for (int s = SH - 1; s >= 0; s--) begin
      sub = W'(m) << s;
      if (v >= sub) v = v - sub;
    end
    return v[MW-1:0];
  endfunction

  always_comb rem_o = reduce(val_i, mod_i);
endmodule

// File: rtl/qpp_lane.sv
// One lane of the address datapath: five register stages, all enabled by adv.
module qpp_lane
  import qpp_pkg::*;
#(
  parameter int LANE = 0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     adv,
  input  idx_t     base_i,
  input  qpp_cfg_t cfg_i,
  output idx_t     addr_o,
  output logic     ok_o
);
  localparam int PW = 2 * IDX_W;
  localparam int XW = IDX_W + 1;

  // stage registers
  logic          ok1_q, ok2_q, ok3_q, ok4_q, ok5_q;
  idx_t          x1_q, x2_q, x3_q;
  logic [PW-1:0] p1_q, p2_q;
  idx_t          r1_q, addr_q;

  // next-state values
  logic [XW-1:0] x_full;
  logic          ok1_d;
  idx_t          x1_d;
  logic [PW-1:0] p1_d, p2_d;
  idx_t          r1_d, sum_red, r2;
  logic [XW-1:0] sum;
  idx_t          addr_d;

  always_comb begin
    x_full = XW'(base_i) + XW'(LANE);
    ok1_d  = x_full < XW'(cfg_i.n);
    // out-of-range lanes feed 0 so the reducer precondition holds
    x1_d   = ok1_d ? x_full[IDX_W-1:0] : '0;
    p1_d   = PW'(cfg_i.f2) * PW'(x1_q);
    sum    = XW'(cfg_i.f1) + XW'(r1_q);
    p2_d   = PW'(sum_red) * PW'(x3_q);
    addr_d = ok4_q ? r2 : '0;
  end

  qpp_modred #(.W(PW), .SH(IDX_W), .MW(IDX_W)) u_red_a (
    .val_i(p1_q), .mod_i(cfg_i.n), .rem_o(r1_d)
  );

  qpp_modred #(.W(XW), .SH(1), .MW(IDX_W)) u_red_s (
    .val_i(sum), .mod_i(cfg_i.n), .rem_o(sum_red)
  );

  qpp_modred #(.W(PW), .SH(IDX_W), .MW(IDX_W)) u_red_b (
    .val_i(p2_q), .mod_i(cfg_i.n), .rem_o(r2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok1_q  <= 1'b0;
      ok2_q  <= 1'b0;
      ok3_q  <= 1'b0;
      ok4_q  <= 1'b0;
      ok5_q  <= 1'b0;
      x1_q   <= '0;
      x2_q   <= '0;
      x3_q   <= '0;
      p1_q   <= '0;
      p2_q   <= '0;
      r1_q   <= '0;
      addr_q <= '0;
    end else if (adv) begin
      ok1_q  <= ok1_d;
      ok2_q  <= ok1_q;
      ok3_q  <= ok2_q;
      ok4_q  <= ok3_q;
      ok5_q  <= ok4_q;
      x1_q   <= x1_d;
      x2_q   <= x1_q;
      x3_q   <= x2_q;
      p1_q   <= p1_d;
      r1_q   <= r1_d;
      p2_q   <= p2_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;
  assign ok_o   = ok5_q;
endmodule

// File: rtl/qpp_ctrl.sv
// Valid pipeline, stall control and configuration capture.
module qpp_ctrl
  import qpp_pkg::*;
#(
  parameter int LAT = 5
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  logic     out_ready,
  input  logic     cfg_load,
  input  qpp_cfg_t cfg_in,
  output logic     req_ready,
  output logic     out_valid,
  output logic     adv,
  output logic     busy,
  output qpp_cfg_t cfg_q
);
  logic [LAT-1:0] vld_q, vld_d;
  qpp_cfg_t       cfg_d;
  logic           accept;

  always_comb begin
    adv       = !vld_q[LAT-1] || out_ready;
    busy      = |vld_q;
    req_ready = adv && !cfg_load;
    accept    = req_valid && req_ready;
    vld_d     = vld_q;
    if (adv) vld_d = {vld_q[LAT-2:0], accept};
    cfg_d     = cfg_q;
    if (cfg_load && !busy) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      cfg_q <= '0;
    end else begin
      vld_q <= vld_d;
      cfg_q <= cfg_d;
    end
  end

  assign out_valid = vld_q[LAT-1];
endmodule

// File: rtl/qpp_addr_gen.sv
module qpp_addr_gen
  import qpp_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [IDX_W-1:0]       cfg_n,
  input  logic [IDX_W-1:0]       cfg_f1,
  input  logic [IDX_W-1:0]       cfg_f2,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [IDX_W-1:0]       req_base,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [LANES*IDX_W-1:0] out_addr,
  output logic [LANES-1:0]       out_lane_ok
);
  localparam int LAT = 5;

  logic     rst_meta_q, rst_sync_n;
  logic     adv, busy;
  qpp_cfg_t cfg_in, cfg_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  always_comb begin
    cfg_in.n  = cfg_n;
    cfg_in.f1 = cfg_f1;
    cfg_in.f2 = cfg_f2;
  end

  qpp_ctrl #(.LAT(LAT)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .req_valid (req_valid),
    .out_ready (out_ready),
    .cfg_load  (cfg_load),
    .cfg_in    (cfg_in),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .adv       (adv),
    .busy      (busy),
    .cfg_q     (cfg_q)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    qpp_lane #(.LANE(i)) u_lane (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .adv    (adv),
      .base_i (req_base),
      .cfg_i  (cfg_q),
      .addr_o (out_addr[i*IDX_W +: IDX_W]),
      .ok_o   (out_lane_ok[i])
    );
  end
endmodule

// File: rtl/qpp_addr_gen_chk.sv
module qpp_addr_gen_chk
  import qpp_pkg::*;
#(
  parameter int LANES = 8
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   cfg_load,
  input logic                   req_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [LANES*IDX_W-1:0] out_addr,
  input logic [LANES-1:0]       out_lane_ok,
  input logic                   busy,
  input logic [3*IDX_W-1:0]     cur_cfg
);
  logic [LANES*IDX_W-1:0] dead_bits;
  idx_t                   cur_n;

  always_comb begin
    cur_n = cur_cfg[3*IDX_W-1 -: IDX_W];
    for (int i = 0; i < LANES; i++)
      dead_bits[i*IDX_W +: IDX_W] = {IDX_W{!out_lane_ok[i]}};
  end

  a_r4_hold_output: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_lane_ok));

  a_r4_no_accept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |-> !req_ready);

  a_r6_load_blocks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_load |-> !req_ready);

  a_r7_busy_load_ignored: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy && cfg_load |=> $stable(cur_cfg));

  a_r2_dead_lane_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_addr & dead_bits) == '0);

  for (genvar i = 0; i < LANES; i++) begin : g_rng
    a_r1_below_n: assert property (@(posedge clk) disable iff (!rst_sync_n)
      out_valid && out_lane_ok[i] |-> out_addr[i*IDX_W +: IDX_W] < cur_n);
  end
endmodule

bind qpp_addr_gen qpp_addr_gen_chk #(.LANES(LANES)) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .cfg_load    (cfg_load),
  .req_ready   (req_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_lane_ok (out_lane_ok),
  .busy        (busy),
  .cur_cfg     (cfg_q)
);

// File: tb/test_qpp_addr_gen.sv
`timescale 1ns/1ps
module test_qpp_addr_gen;
  localparam int IW = 13;
  localparam int NL = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_load;
  logic [IW-1:0]   cfg_n, cfg_f1, cfg_f2;
  logic            req_valid, req_ready;
  logic [IW-1:0]   req_base;
  logic            out_valid, out_ready;
  logic [NL*IW-1:0] out_addr;
  logic [NL-1:0]   out_lane_ok;

  int total = 0;
  int bad   = 0;
  int seen [6144];
  int q_base [$];

  always #2.5 clk = ~clk;

  qpp_addr_gen i_qpp_addr_gen (
    .clk, .rst_n, .cfg_load, .cfg_n, .cfg_f1, .cfg_f2,
    .req_valid, .req_ready, .req_base,
    .out_valid, .out_ready, .out_addr, .out_lane_ok
  );

  function automatic longint ref_addr(longint n, longint f1, longint f2, longint x);
    return (f1 * x + f2 * x * x) % n;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // checks all lanes of the current output against base b
  task automatic chk_group(string tag, int b, int n, int f1, int f2, bit perm);
    for (int i = 0; i < NL; i++) begin
      int  x;
      bit  ok_exp;
      x = b + i;
      ok_exp = (x < n);
      chk({tag, " R2 lane flag"}, out_lane_ok[i], ok_exp);
      if (ok_exp) begin
        chk({tag, " R1 address"}, out_addr[i*IW +: IW], ref_addr(n, f1, f2, x));
        if (perm) seen[out_addr[i*IW +: IW]]++;
      end else begin
        chk({tag, " R2 dead lane zero"}, out_addr[i*IW +: IW], 0);
      end
    end
  endtask

  task automatic load_cfg(int n, int f1, int f2);
    @(negedge clk);
    cfg_load = 1'b1;
    cfg_n = IW'(n); cfg_f1 = IW'(f1); cfg_f2 = IW'(f2);
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic one_shot(int b, int n, int f1, int f2, string tag);
    @(negedge clk);
    out_ready = 1'b1;
    req_valid = 1'b1;
    req_base  = IW'(b);
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!out_valid) @(negedge clk);
    chk_group(tag, b, n, f1, f2, 1'b0);
    @(posedge clk);
  endtask

  // streaming run with random valid/ready; mode 0 sequential bases, 1 random
  task automatic stream(int n, int f1, int f2, int start, int count, int mode,
                        bit perm, string tag);
    int sent = 0;
    int nxt  = start;
    bit took = 1'b0;
    q_base.delete();
    while (sent < count || q_base.size() != 0) begin
      @(negedge clk);
      if (took) req_valid = 1'b0;
      took = 1'b0;
      out_ready = ($urandom % 4) != 0;
      if (!req_valid && sent < count && ($urandom % 4) != 0) begin
        req_valid = 1'b1;
        if (mode == 0) begin
          req_base = IW'(nxt);
          nxt += NL;
        end else begin
          req_base = IW'($urandom % (n + NL));
        end
      end
      #1;
      if (out_valid && out_ready) begin
        int b;
        // R5: results arrive in request order
        if (q_base.size() == 0) chk({tag, " R5 unexpected output"}, 1, 0);
        else begin
          b = q_base.pop_front();
          chk_group(tag, b, n, f1, f2, perm);
        end
      end
      if (req_valid && req_ready) begin
        q_base.push_back(int'(req_base));
        sent++;
        took = 1'b1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic perm_sweep(int n, int f1, int f2);
    int errs = 0;
    for (int a = 0; a < 6144; a++) seen[a] = 0;
    load_cfg(n, f1, f2);
    stream(n, f1, f2, 0, (n + NL - 1) / NL, 0, 1'b1, "sweep");
    for (int a = 0; a < n; a++) if (seen[a] != 1) errs++;
    chk($sformatf("R9 permutation N=%0d miss/dup count", n), errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [NL*IW-1:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_load = 1'b0; cfg_n = '0; cfg_f1 = '0; cfg_f2 = '0;
    req_valid = 1'b0; req_base = '0; out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 out_valid after reset", out_valid, 0);
    chk("R8 req_ready after reset", req_ready, 1);

    // R3 latency and R4 stall
    load_cfg(40, 3, 10);
    req_valid = 1'b1; req_base = IW'(16); out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 out_valid low before edge k+4", out_valid, 0);
    @(posedge clk);
    @(negedge clk);
    chk("R3 out_valid high after edge k+4", out_valid, 1);
    chk_group("R3", 16, 40, 3, 10, 1'b0);
    out_ready = 1'b0;
    held = out_addr;
    @(posedge clk);
    @(negedge clk);
    chk("R4 valid held under stall", out_valid, 1);
    chk("R4 address held under stall", (out_addr == held), 1);
    chk("R4 req_ready low under stall", req_ready, 0);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R4 output taken after release", out_valid, 0);

    // R2 partial group at the end of the block
    one_shot(37, 40, 3, 10, "R2 base N-3");

    // R7 load while busy, R6 load while idle
    @(negedge clk);
    req_valid = 1'b1; req_base = IW'(8);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    cfg_load = 1'b1; cfg_n = IW'(1024); cfg_f1 = IW'(31); cfg_f2 = IW'(64);
    #1;
    chk("R6 req_ready low during load", req_ready, 0);
    @(posedge clk);
    @(negedge clk);
    cfg_load = 1'b0;
    while (!out_valid) @(negedge clk);
    chk_group("R7 in-flight keeps old cfg", 8, 40, 3, 10, 1'b0);
    @(posedge clk);
    one_shot(24, 40, 3, 10, "R7 later request keeps old cfg");
    load_cfg(1024, 31, 64);
    one_shot(1000, 1024, 31, 64, "R6 new cfg after idle load");

    // R9 permutation sweeps with random backpressure (also R1, R5)
    perm_sweep(40, 3, 10);
    perm_sweep(512, 31, 64);
    perm_sweep(1024, 31, 64);
    perm_sweep(6144, 263, 480);

    // R1 arbitrary N and coefficients, random bases past N (R2)
    for (int t = 0; t < 4; t++) begin
      int n, f1, f2;
      n  = 1 + ($urandom % 6144);
      f1 = $urandom % n;
      f2 = $urandom % n;
      if (t == 0) begin n = 6144; f1 = 6143; f2 = 6143; end
      load_cfg(n, f1, f2);
      stream(n, f1, f2, 0, 60, 1, 1'b0, "random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule